// File: doc/BRIEF.md
# Auto-Detecting Serial Register Port

This block is a slave serial control port that sits between an external host and a small on-chip register bus. Every transaction is two bytes: a command byte that carries a read/write flag and a 6-bit register address, then one data byte that either goes to the register bus as a write or comes back from it as a read. The block serves two host styles without any configuration. When chip select falls, the serial clock level chooses the protocol for that transaction. A high clock selects the least-significant-bit-first style of 8051 serial mode 0, which uses one bidirectional data pin. A low clock selects the most-significant-bit-first style of SPI mode 0 and Microwire, which uses separate receive and transmit pins.

The serial pins are asynchronous to the block clock. They are synchronized and edge-detected inside, so the block clock must be several times faster than the serial clock. The shared pin appears as an input, an output and an output enable, and the pad tri-state sits outside the block. Register contents live outside the block.

Top module: `auto_sport`

## Requirements
- R1: The serial clock level seen when chip select falls sets the mode for the whole transaction. High selects LSB-first order with receive on `dio_i`. Low selects MSB-first order with receive on `din_i`. Both bytes of a read return the register value correctly in either mode.
- R2: In LSB-first mode, `din_i` is ignored. `dio_oe_o` stays low during the command byte and during write transactions.
- R3: In MSB-first mode, `dio_i` is ignored, and `dio_oe_o` is high while chip select is low.
- R4: Command byte fields are bit 7 for direction (1 = read, 0 = write), bit 6 for a reserved bit that is ignored, and bits 5..0 for the register address. In LSB-first mode, bit 0 arrives first and bit 7 arrives last.
- R5: A write raises `reg_we_o` for exactly one clock after the 16th rising serial-clock edge. At that point `reg_addr_o` and `reg_wdata_o` hold the received address and data.
- R6: A transaction ended by chip select rising before the 16th rising edge produces no write strobe, and the target register keeps its value.
- R7: A read raises `reg_re_o` for exactly one clock after the 8th rising edge and captures `reg_rdata_i` in that clock. The byte is driven on `dio_o`, one bit per falling edge starting with the 8th falling edge after the command, in the mode's bit order and with `dio_oe_o` high.
- R8: Within four block-clock cycles of chip select rising, `dio_oe_o` goes low. It stays low while chip select is high.
- R9: A read transaction never raises `reg_we_o`, and a write transaction never raises `reg_re_o`. The two strobes are never high together.
- R10: Serial clocks beyond the 16th within one transaction are ignored and cause no further strobe.
- R11: After reset, `dio_oe_o`, `reg_we_o` and `reg_re_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock, several times the serial clock rate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock from the host |
| cs_ni | input | 1 | Active-low chip select |
| dio_i | input | 1 | Shared data pin, input side (receive in LSB-first mode) |
| din_i | input | 1 | Receive pin in MSB-first mode |
| dio_o | output | 1 | Shared data pin, output side |
| dio_oe_o | output | 1 | Output enable for the shared data pin |
| reg_we_o | output | 1 | Register write strobe, one clock |
| reg_re_o | output | 1 | Register read strobe, one clock |
| reg_addr_o | output | 6 | Register address from the command byte |
| reg_wdata_o | output | 8 | Register write data |
| reg_rdata_i | input | 8 | Register read data, valid in the read strobe clock |

## Verification
The hardest case to reach from the ports is an LSB-first read. Here the direction bit arrives last, so the register fetch and the load of the first output bit must both finish in the few block clocks between the 8th rising edge and the next falling edge, on a pin the host has just used to send. The bench models the host cycle by cycle in both modes and drives the inverse of each bit on the unused receive pin. It also drives garbage on the receive pin during read data, so a design that listens on the wrong pin produces wrong bytes. Chip select cut short at 12 bits and a transaction stretched to 20 clocks are followed by read-backs, so any stray write shows up at the ports.

// File: rtl/auto_sport_pkg.sv
package auto_sport_pkg;
  typedef enum logic {
    ORDER_MSB = 1'b0,
    ORDER_LSB = 1'b1
  } bit_order_e;

  // Serial input vector positions after synchronization
  localparam int unsigned SIN_DIN  = 0;
  localparam int unsigned SIN_DIO  = 1;
  localparam int unsigned SIN_CSN  = 2;
  localparam int unsigned SIN_SCLK = 3;
  localparam int unsigned SIN_W    = 4;
endpackage

// File: rtl/auto_sport_sync.sv
module auto_sport_sync #(
  parameter int unsigned      WIDTH   = 1,
  parameter int unsigned      STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [WIDTH-1:0] q;
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) q <= RST_VAL;
        else         q <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) q <= RST_VAL;
        else         q <= g_stage[g-1].q;
    end
  end

  assign q_o = g_stage[STAGES-1].q;
endmodule

// File: rtl/auto_sport_rx.sv
module auto_sport_rx
  import auto_sport_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned CNT_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_s_i,
  input  logic              cs_n_s_i,
  input  logic              dio_s_i,
  input  logic              din_s_i,
  input  logic              sclk_rise_i,
  input  logic              cs_fall_i,
  output logic              active_o,
  output logic              mode_lsb_o,
  output logic              cmd_rd_o,
  output logic [CNT_W-1:0]  bit_cnt_o,
  output logic              reg_we_o,
  output logic              reg_re_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o
);
  localparam int unsigned FRAME_BITS = 2 * DATA_W;
  localparam logic [CNT_W-1:0] CNT_CMD_LAST = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] CNT_DAT_LAST = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] CNT_FULL     = CNT_W'(FRAME_BITS);

  bit_order_e        order_q;
  logic              active_q, cmd_rd_q, we_q, re_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] sr_q, sr_nxt, wdata_q;
  logic [ADDR_W-1:0] addr_q;
  logic              rx_bit;

  assign rx_bit = (order_q == ORDER_LSB) ? dio_s_i : din_s_i;
  assign sr_nxt = (order_q == ORDER_LSB) ? {rx_bit, sr_q[DATA_W-1:1]}
                                         : {sr_q[DATA_W-2:0], rx_bit};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      order_q  <= ORDER_MSB;
      active_q <= 1'b0;
      cmd_rd_q <= 1'b0;
      cnt_q    <= '0;
      sr_q     <= '0;
      addr_q   <= '0;
      wdata_q  <= '0;
      we_q     <= 1'b0;
      re_q     <= 1'b0;
    end else begin
      we_q <= 1'b0;
      re_q <= 1'b0;
      if (cs_n_s_i) begin
        active_q <= 1'b0;
      end else if (cs_fall_i) begin
        active_q <= 1'b1;
        order_q  <= sclk_s_i ? ORDER_LSB : ORDER_MSB;
        cnt_q    <= '0;
        cmd_rd_q <= 1'b0;
      end else if (active_q && sclk_rise_i && cnt_q != CNT_FULL) begin
        sr_q  <= sr_nxt;
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CNT_CMD_LAST) begin
          cmd_rd_q <= sr_nxt[DATA_W-1];
          addr_q   <= sr_nxt[ADDR_W-1:0];
          re_q     <= sr_nxt[DATA_W-1];
        end
        // commit only once the whole frame is in
        if (cnt_q == CNT_DAT_LAST && !cmd_rd_q) begin
          wdata_q <= sr_nxt;
          we_q    <= 1'b1;
        end
      end
    end
  end

  assign active_o    = active_q;
  assign mode_lsb_o  = (order_q == ORDER_LSB);
  assign cmd_rd_o    = cmd_rd_q;
  assign bit_cnt_o   = cnt_q;
  assign reg_we_o    = we_q;
  assign reg_re_o    = re_q;
  assign reg_addr_o  = addr_q;
  assign reg_wdata_o = wdata_q;
endmodule

// File: rtl/auto_sport_tx.sv
module auto_sport_tx #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              mode_lsb_i,
  input  logic              cmd_rd_i,
  input  logic [CNT_W-1:0]  bit_cnt_i,
  input  logic              sclk_fall_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              dio_o,
  output logic              dio_oe_o
);
  localparam logic [CNT_W-1:0] CNT_DAT_FIRST = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] CNT_FULL      = CNT_W'(2 * DATA_W);

  logic [DATA_W-1:0] sr_q;
  logic              dout_q, oe_q, shift_en;

  assign shift_en = sclk_fall_i && cmd_rd_i &&
                    bit_cnt_i >= CNT_DAT_FIRST && bit_cnt_i < CNT_FULL;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      dout_q <= 1'b0;
      oe_q   <= 1'b0;
    end else if (!active_i) begin
      dout_q <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      if (load_i) begin
        sr_q <= rdata_i;
      end else if (shift_en) begin
        dout_q <= mode_lsb_i ? sr_q[0] : sr_q[DATA_W-1];
        sr_q   <= mode_lsb_i ? (sr_q >> 1) : (sr_q << 1);
        oe_q   <= 1'b1;
      end
      // split-pin mode owns the transmit pin for the whole transaction
      if (!mode_lsb_i) oe_q <= 1'b1;
    end
  end

  assign dio_o    = dout_q;
  assign dio_oe_o = oe_q;
endmodule

// File: rtl/auto_sport.sv
module auto_sport
  import auto_sport_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned ADDR_W      = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              cs_ni,
  input  logic              dio_i,
  input  logic              din_i,
  output logic              dio_o,
  output logic              dio_oe_o,
  output logic              reg_we_o,
  output logic              reg_re_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  input  logic [DATA_W-1:0] reg_rdata_i
);
  localparam int unsigned FRAME_BITS = 2 * DATA_W;
  localparam int unsigned CNT_W      = $clog2(FRAME_BITS + 1);
  localparam logic [SIN_W-1:0] SIN_IDLE = SIN_W'(1) << SIN_CSN;

  logic [SIN_W-1:0] sin_raw, sin_s;
  logic             sclk_q, csn_q;
  logic             sclk_rise, sclk_fall, cs_fall;
  logic             active, mode_lsb, cmd_rd;
  logic [CNT_W-1:0] bit_cnt;

  always_comb begin
    sin_raw           = '0;
    sin_raw[SIN_SCLK] = sclk_i;
    sin_raw[SIN_CSN]  = cs_ni;
    sin_raw[SIN_DIO]  = dio_i;
    sin_raw[SIN_DIN]  = din_i;
  end

  auto_sport_sync #(
    .WIDTH  (SIN_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(SIN_IDLE)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (sin_raw),
    .q_o   (sin_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      csn_q  <= 1'b1;
    end else begin
      sclk_q <= sin_s[SIN_SCLK];
      csn_q  <= sin_s[SIN_CSN];
    end
  end

  assign sclk_rise = sin_s[SIN_SCLK] & ~sclk_q;
  assign sclk_fall = ~sin_s[SIN_SCLK] & sclk_q;
  assign cs_fall   = ~sin_s[SIN_CSN] & csn_q;

  auto_sport_rx #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W),
    .CNT_W (CNT_W)
  ) u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sclk_s_i   (sin_s[SIN_SCLK]),
    .cs_n_s_i   (sin_s[SIN_CSN]),
    .dio_s_i    (sin_s[SIN_DIO]),
    .din_s_i    (sin_s[SIN_DIN]),
    .sclk_rise_i(sclk_rise),
    .cs_fall_i  (cs_fall),
    .active_o   (active),
    .mode_lsb_o (mode_lsb),
    .cmd_rd_o   (cmd_rd),
    .bit_cnt_o  (bit_cnt),
    .reg_we_o   (reg_we_o),
    .reg_re_o   (reg_re_o),
    .reg_addr_o (reg_addr_o),
    .reg_wdata_o(reg_wdata_o)
  );

  auto_sport_tx #(
    .DATA_W(DATA_W),
    .CNT_W (CNT_W)
  ) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .active_i   (active),
    .mode_lsb_i (mode_lsb),
    .cmd_rd_i   (cmd_rd),
    .bit_cnt_i  (bit_cnt),
    .sclk_fall_i(sclk_fall),
    .load_i     (reg_re_o),
    .rdata_i    (reg_rdata_i),
    .dio_o      (dio_o),
    .dio_oe_o   (dio_oe_o)
  );
endmodule

// File: rtl/auto_sport_chk.sv
module auto_sport_chk #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_ni,
  input logic dio_oe_o,
  input logic reg_we_o,
  input logic reg_re_o,
  input logic mode_lsb,
  input logic cmd_rd
);
  localparam int unsigned HI_LIMIT = SYNC_STAGES + 2;

  logic [7:0] hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                hi_cnt <= '0;
    else if (!cs_ni)            hi_cnt <= '0;
    else if (hi_cnt != 8'hFF)   hi_cnt <= hi_cnt + 1'b1;
  end

  // R5
  we_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o);

  // R7
  re_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_re_o |=> !reg_re_o);

  // R9
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_o && reg_re_o));

  // R8
  oe_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_cnt > 8'(HI_LIMIT)) |-> !dio_oe_o);

  // R2
  lsb_oe_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dio_oe_o && mode_lsb) |-> cmd_rd);
endmodule

bind auto_sport auto_sport_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cs_ni   (cs_ni),
  .dio_oe_o(dio_oe_o),
  .reg_we_o(reg_we_o),
  .reg_re_o(reg_re_o),
  .mode_lsb(mode_lsb),
  .cmd_rd  (cmd_rd)
);

// File: tb/sim_auto_sport.sv
module sim_auto_sport;
  localparam int H = 8;  // block clocks per serial half period
  // {lsb, rd, rsv, addr[5:0], data[7:0]}
  localparam int NV = 8;
  localparam logic [16:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b0, 6'h05, 8'hA3},
    {1'b1, 1'b0, 1'b0, 6'h2A, 8'h5C},
    {1'b0, 1'b0, 1'b1, 6'h3F, 8'h81},
    {1'b1, 1'b0, 1'b0, 6'h00, 8'h7E},
    {1'b0, 1'b1, 1'b0, 6'h2A, 8'h5C},
    {1'b1, 1'b1, 1'b0, 6'h05, 8'hA3},
    {1'b1, 1'b1, 1'b1, 6'h3F, 8'h81},
    {1'b0, 1'b1, 1'b0, 6'h00, 8'h7E}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sclk_i = 1'b0, cs_ni = 1'b1, dio_i = 1'b0, din_i = 1'b0;
  logic dio_o, dio_oe_o, reg_we_o, reg_re_o;
  logic [5:0] reg_addr_o;
  logic [7:0] reg_wdata_o, reg_rdata_i;
  logic [7:0] mem [64];
  int we_cnt = 0, re_cnt = 0;
  logic [5:0] last_addr;
  logic [7:0] last_data;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  auto_sport u0 (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk_i), .cs_ni(cs_ni),
    .dio_i(dio_i), .din_i(din_i), .dio_o(dio_o), .dio_oe_o(dio_oe_o),
    .reg_we_o(reg_we_o), .reg_re_o(reg_re_o), .reg_addr_o(reg_addr_o),
    .reg_wdata_o(reg_wdata_o), .reg_rdata_i(reg_rdata_i)
  );

  assign reg_rdata_i = mem[reg_addr_o];

  always @(posedge clk) begin
    if (reg_we_o) begin
      we_cnt    <= we_cnt + 1;
      last_addr <= reg_addr_o;
      last_data <= reg_wdata_o;
      mem[reg_addr_o] <= reg_wdata_o;
    end
    if (reg_re_o) re_cnt <= re_cnt + 1;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic xfer(input bit lsb, input logic [7:0] cmd, input logic [7:0] dat,
                      input int nbits, output logic [7:0] got, output bit oe_cmd,
                      output bit oe_dat);
    logic [7:0] byt;
    logic b;
    int idx;
    got = '0; oe_cmd = 1'b0; oe_dat = 1'b1;
    @(negedge clk) sclk_i = lsb;
    repeat (H) @(negedge clk);
    cs_ni = 1'b0;
    repeat (H) @(negedge clk);
    for (int k = 0; k < nbits; k++) begin
      if (lsb) sclk_i = 1'b0;
      byt = (k < 8) ? cmd : dat;
      idx = lsb ? (k % 8) : (7 - (k % 8));
      b   = (k < 16) ? byt[idx] : 1'b0;
      if (lsb) begin dio_i = b; din_i = ~b; end
      else     begin din_i = b; dio_i = ~b; end
      repeat (H) @(negedge clk);
      if (k == 2) oe_cmd = dio_oe_o;
      if (k >= 8 && k < 16) begin
        got[lsb ? (k - 8) : (15 - k)] = dio_o;
        if (!dio_oe_o) oe_dat = 1'b0;
      end
      sclk_i = 1'b1;
      repeat (H) @(negedge clk);
      if (!lsb) sclk_i = 1'b0;
    end
    repeat (H) @(negedge clk);
    cs_ni = 1'b1;
    repeat (2 * H) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] got;
    bit oe_c, oe_d;
    int we0, re0;
    for (int i = 0; i < 64; i++) mem[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    // R11 reset state
    check("R11 oe", dio_oe_o, 0);
    check("R11 we", reg_we_o, 0);
    check("R11 re", reg_re_o, 0);

    for (int i = 0; i < NV; i++) begin
      logic [16:0] v;
      logic [7:0] cmd;
      v   = VEC[i];
      cmd = {v[15], v[14], v[13:8]};
      we0 = we_cnt; re0 = re_cnt;
      xfer(v[16], cmd, v[15] ? 8'hFF : v[7:0], 16, got, oe_c, oe_d);
      if (!v[15]) begin
        check("R5 one write strobe", we_cnt - we0, 1);
        check("R4 address", last_addr, v[13:8]);
        check(v[16] ? "R2 lsb write data" : "R3 msb write data", last_data, v[7:0]);
        check("R9 no read strobe on write", re_cnt - re0, 0);
        if (v[16]) check("R2 oe low in lsb write", oe_c, 0);
        else       check("R3 oe high in msb", oe_c, 1);
      end else begin
        check("R1 read data", got, v[7:0]);
        check("R7 one read strobe", re_cnt - re0, 1);
        check("R7 oe during data", oe_d, 1);
        check("R9 no write strobe on read", we_cnt - we0, 0);
        if (v[16]) check("R2 oe low in lsb command", oe_c, 0);
      end
      check("R8 oe low after cs", dio_oe_o, 0);
    end

    // R6 early chip select rise: no write
    we0 = we_cnt;
    xfer(1'b0, 8'h05, 8'h11, 12, got, oe_c, oe_d);
    check("R6 no strobe on short frame", we_cnt - we0, 0);
    xfer(1'b1, 8'h85, 8'hFF, 16, got, oe_c, oe_d);
    check("R6 register kept", got, 8'hA3);

    // R10 extra clocks ignored
    we0 = we_cnt;
    xfer(1'b1, 8'h10, 8'h3C, 20, got, oe_c, oe_d);
    check("R10 single strobe with extra clocks", we_cnt - we0, 1);
    check("R10 data", last_data, 8'h3C);
    xfer(1'b0, 8'h90, 8'hFF, 16, got, oe_c, oe_d);
    check("R10 read back", got, 8'h3C);
    check("R8 oe low idle", dio_oe_o, 0);

    summary();
    $finish;
  end
endmodule